// File: doc/BRIEF.md
# 64-Bit Single-Error-Correcting Codeword Encoder

This block turns a 64-bit data word into a 71-bit codeword. A receiver can use that codeword to find and flip any single corrupted bit. Seven even-parity check bits sit at the power-of-two positions of the codeword, and the data bits fill the other positions in ascending order. The codeword is one flat vector with codeword position 1 in its most significant bit. Position p of the codeword is vector bit 71 − p.

The parity network is combinational. A parameter chooses whether the codeword leaves the block directly or through one output register stage. That stage carries a valid flag alongside the codeword and captures a new word on every cycle in which the input is marked valid, so back-to-back words are accepted at full rate. The synchronous reset clears the valid flag. Reset takes priority over a word that is offered in the same cycle.

Top module: `hsec_enc64`

## Requirements
- R1: The number of check bits is the smallest r with 2^r ≥ 64 + r + 1, which is 7, so the codeword is 71 bits wide. Check bits occupy codeword positions 1, 2, 4, 8, 16, 32 and 64. Position p appears on `code_o` bit 71 − p.
- R2: Data bit `data_i[63]` (the first data bit) is placed at codeword position 3. Each following data bit, in descending `data_i` index, takes the next non-power-of-two position. So `data_i[62]` is at position 5, `data_i[61]` at 6, `data_i[60]` at 7, `data_i[59]` at 9, and `data_i[0]` at position 71.
- R3: The check bit at position 2^k equals the XOR of all data bits whose position has bit k set. Every emitted codeword therefore has an all-zero syndrome: the XOR of the positions of all its one bits is 0.
- R4: For `data_i` = 64'h5555_5555_5555_5555, `code_o` equals 71'h25AA5555AAAAAAAA55.
- R5: In the registered variant (the default), a word offered with `valid_i` high and reset low appears on `code_o`, with `valid_o` high, after the next rising clock edge. Consecutive valid words emerge in order, one per cycle, each exactly once.
- R6: `valid_o` is low during and after a synchronous reset. It stays low after an edge at which `rst` and `valid_i` are both high.
- R7: After an edge at which `valid_i` is low, `valid_o` is low and `code_o` keeps its previous value, whatever `data_i` holds.
- R8: Flipping any one data bit changes at least three bits of the codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Data word offered this cycle |
| data_i | input | 64 | Data word; bit 63 is the first data bit |
| valid_o | output | 1 | Codeword on `code_o` is new |
| code_o | output | 71 | Codeword; bit 70 is codeword position 1 |

## Verification
Two of this block's functions can land on the same rising edge. A reset can coincide with a valid input word, and the capture of a new word can coincide with the presentation of the previous one during back-to-back traffic. The bench raises reset together with a valid word and then requires `valid_o` to stay low, with no codeword reaching the scoreboard. It also streams unbroken runs of valid words, each of which must surface exactly once, in order, with the independently computed codeword and a zero syndrome.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

    // smallest r with 2^r >= m + r + 1
    function automatic int chk_bits(input int m);
        int r;
        r = 0;
        while ((1 << r) < (m + r + 1)) begin
            r++;
        end
        return r;
    endfunction

    function automatic bit is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // 1-based data index held at a non-power-of-two codeword position
    function automatic int data_idx(input int p);
        return p - $clog2(p + 1);
    endfunction

    // bit index of a power-of-two position
    function automatic int pow2_log(input int p);
        return $clog2(p);
    endfunction

endpackage

// File: rtl/hsec_scatter.sv
module hsec_scatter
    import hsec_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CODE_W = DATA_W + chk_bits(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W:1]   slots_o
);

    // data bit n (1-based) comes from data_i[DATA_W-n]; check slots stay 0
    for (genvar p = 1; p <= CODE_W; p++) begin : g_slot
        if (is_pow2(p)) begin : g_chk
            assign slots_o[p] = 1'b0;
        end else begin : g_dat
            assign slots_o[p] = data_i[DATA_W - data_idx(p)];
        end
    end

endmodule

// File: rtl/hsec_checkgen.sv
module hsec_checkgen #(
    parameter int CODE_W = 71,
    parameter int CHK_W  = 7
) (
    input  logic [CODE_W:1]  slots_i,
    output logic [CHK_W-1:0] chk_o
);

    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        always_comb begin
            chk_o[k] = 1'b0;
            for (int p = 1; p <= CODE_W; p++) begin
                if (((p >> k) & 1) == 1) begin
                    chk_o[k] = chk_o[k] ^ slots_i[p];
                end
            end
        end
    end

endmodule

// File: rtl/hsec_outreg.sv
module hsec_outreg #(
    parameter int CODE_W = 71
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              valid_o,
    output logic [CODE_W-1:0] code_o
);

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] code;
    } stage_t;

    stage_t stage_d;
    stage_t stage_q;

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = valid_i;
        if (valid_i) begin
            stage_d.code = code_i;
        end
        if (rst) begin
            stage_d.vld  = 1'b0;
            stage_d.code = '0;
        end
    end

    always_ff @(posedge clk) begin
        stage_q <= stage_d;
    end

    assign valid_o = stage_q.vld;
    assign code_o  = stage_q.code;

endmodule

// File: rtl/hsec_enc64.sv
module hsec_enc64
    import hsec_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter bit REGISTERED = 1'b1,
    parameter int CHK_W      = chk_bits(DATA_W),
    parameter int CODE_W     = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [CODE_W-1:0] code_o
);

    logic [CODE_W:1]   slots;
    logic [CHK_W-1:0]  chk;
    logic [CODE_W-1:0] code_d;

    hsec_scatter #(
        .DATA_W (DATA_W),
        .CODE_W (CODE_W)
    ) u_scatter (
        .data_i  (data_i),
        .slots_o (slots)
    );

    hsec_checkgen #(
        .CODE_W (CODE_W),
        .CHK_W  (CHK_W)
    ) u_checkgen (
        .slots_i (slots),
        .chk_o   (chk)
    );

    // position p drives vector bit CODE_W-p
    for (genvar p = 1; p <= CODE_W; p++) begin : g_merge
        if (is_pow2(p)) begin : g_chk
            assign code_d[CODE_W - p] = chk[pow2_log(p)];
        end else begin : g_dat
            assign code_d[CODE_W - p] = slots[p];
        end
    end

    if (REGISTERED) begin : g_reg
        hsec_outreg #(
            .CODE_W (CODE_W)
        ) u_outreg (
            .clk     (clk),
            .rst     (rst),
            .valid_i (valid_i),
            .code_i  (code_d),
            .valid_o (valid_o),
            .code_o  (code_o)
        );
    end else begin : g_comb
        assign valid_o = valid_i;
        assign code_o  = code_d;
    end

endmodule

// File: rtl/hsec_enc64_chk.sv
module hsec_enc64_chk
    import hsec_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter bit REGISTERED = 1'b1,
    parameter int CHK_W      = chk_bits(DATA_W),
    parameter int CODE_W     = DATA_W + CHK_W
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [DATA_W-1:0] data_i,
    input logic              valid_o,
    input logic [CODE_W-1:0] code_o
);

    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] ext;

    // recover syndrome and data from the emitted codeword
    always_comb begin
        int d;
        syn = '0;
        ext = '0;
        d   = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (code_o[CODE_W - p]) begin
                syn = syn ^ CHK_W'(p);
            end
            if (!is_pow2(p)) begin
                d = d + 1;
                ext[DATA_W - d] = code_o[CODE_W - p];
            end
        end
    end

    // R3: every presented codeword checks clean
    a_r3_zero_syndrome: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (syn == '0));

    if (REGISTERED) begin : g_seq
        // R5: a valid word is presented on the next edge
        a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
            valid_i |=> valid_o);

        // R2: the data field of the output carries the captured word
        a_r2_data_placed: assert property (@(posedge clk) disable iff (rst)
            valid_i |=> (ext == $past(data_i)));

        // R6: reset clears the valid flag even with a word offered
        a_r6_reset_clears: assert property (@(posedge clk)
            rst |=> !valid_o);

        // R7: idle input leaves the codeword untouched
        a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
            !valid_i |=> (!valid_o && $stable(code_o)));
    end

endmodule

bind hsec_enc64 hsec_enc64_chk #(
    .DATA_W     (DATA_W),
    .REGISTERED (REGISTERED),
    .CHK_W      (CHK_W),
    .CODE_W     (CODE_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid_i),
    .data_i  (data_i),
    .valid_o (valid_o),
    .code_o  (code_o)
);

// File: tb/sim_hsec_enc64.sv
`timescale 1ns/1ps
module sim_hsec_enc64;

    localparam int DW = 64;
    localparam int CW = 71;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid_i = 1'b0;
    logic [DW-1:0] data_i = '0;
    logic          valid_o;
    logic [CW-1:0] code_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [CW-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    hsec_enc64 u0 (
        .clk     (clk),
        .rst     (rst),
        .valid_i (valid_i),
        .data_i  (data_i),
        .valid_o (valid_o),
        .code_o  (code_o)
    );

    // model from the requirements: positions 1..71, checks at powers of two
    function automatic logic [CW-1:0] model(input logic [DW-1:0] d);
        logic cw [1:CW];
        logic [CW-1:0] v;
        int n;
        n = 0;
        for (int p = 1; p <= CW; p++) begin
            if ((p & (p - 1)) == 0) begin
                cw[p] = 1'b0;
            end else begin
                n++;
                cw[p] = d[DW - n];
            end
        end
        for (int k = 0; k < 7; k++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p <= CW; p++) begin
                if (((p >> k) & 1) == 1 && p != (1 << k)) par = par ^ cw[p];
            end
            cw[1 << k] = par;
        end
        for (int p = 1; p <= CW; p++) v[CW - p] = cw[p];
        return v;
    endfunction

    function automatic int syndrome(input logic [CW-1:0] v);
        int s;
        s = 0;
        for (int p = 1; p <= CW; p++) if (v[CW - p]) s = s ^ p;
        return s;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [CW-1:0] act,
                         input logic [CW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [DW-1:0] d);
        @(negedge clk);
        valid_i = 1'b1;
        data_i  = d;
        exp_q.push_back(model(d));
    endtask

    task automatic idle();
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    function automatic logic [DW-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    // scoreboard monitor: R1, R2, R3, R5, R7
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected valid_o", code_o, '0);
            end else begin
                logic [CW-1:0] e;
                e = exp_q.pop_front();
                check(code_o === e, "R1/R2/R5 codeword", code_o, e);
                check(syndrome(code_o) == 0, "R3 syndrome", CW'(syndrome(code_o)), '0);
            end
        end
    end

    initial begin
        logic [CW-1:0] held;
        logic [DW-1:0] a;
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R6 valid_o in reset", CW'(valid_o), '0);
        rst = 1'b0;

        // R4 known answer
        send(64'h5555_5555_5555_5555);
        idle();
        check(code_o === 71'h25AA5555AAAAAAAA55, "R4 known answer", code_o,
              71'h25AA5555AAAAAAAA55);

        // R5 back-to-back corner patterns and random words
        send('0);
        send('1);
        send(64'h8000_0000_0000_0000);
        send(64'h0000_0000_0000_0001);
        for (int i = 0; i < DW; i++) send(64'h1 << i);
        for (int i = 0; i < 200; i++) send(rnd64());
        idle();
        idle();

        // R7 idle input holds the codeword
        send(64'hDEAD_BEEF_0123_4567);
        @(negedge clk);
        valid_i = 1'b0;
        data_i  = ~data_i;
        held    = code_o;
        @(negedge clk);
        check(valid_o == 1'b0, "R7 valid_o drops", CW'(valid_o), '0);
        check(code_o === held, "R7 code held", code_o, held);

        // R6 reset together with a valid word
        @(negedge clk);
        rst     = 1'b1;
        valid_i = 1'b1;
        data_i  = 64'hFFFF_0000_FFFF_0000;
        @(negedge clk);
        check(valid_o == 1'b0, "R6 reset beats valid", CW'(valid_o), '0);
        rst     = 1'b0;
        valid_i = 1'b0;
        idle();
        check(valid_o == 1'b0, "R6 no late output", CW'(valid_o), '0);

        // R8 one flipped data bit moves at least three codeword bits
        for (int i = 0; i < 16; i++) begin
            logic [CW-1:0] c0;
            logic [CW-1:0] c1;
            int b;
            a = rnd64();
            b = (i * 5 + 3) % DW;
            send(a);
            @(negedge clk);
            valid_i = 1'b0;
            c0 = code_o;
            send(a ^ (64'h1 << b));
            @(negedge clk);
            valid_i = 1'b0;
            c1 = code_o;
            check($countones(c0 ^ c1) >= 3, "R8 distance", c0 ^ c1, '0);
        end

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R5 all words emitted", CW'(exp_q.size()), '0);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule